// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Scheduler

This block sits on the controller side of an SDRAM. It keeps the array refreshed and moves the device into and out of its low-power states. An internal cycle counter makes the block owe one auto-refresh every `REF_INTERVAL` clocks. If the controller reports that a bank is open, the block closes all banks with a precharge-all command and waits `T_RP` cycles before it issues the refresh. The memory counts refresh rows internally, so the refresh command carries no address. The memory also closes its own banks after a refresh, so no precharge follows it.

The host asks for self-refresh with `sleep_req`, for power-down with `pd_req`, and for a return to normal operation with a pulse on `wake_req`. The block enters self-refresh only when an auto-refresh finished less than `SR_WINDOW` cycles earlier. If that window has passed, it refreshes first. When the device leaves self-refresh, one refresh is owed at once. Power-down stops the memory's own refresh, so the block also leaves power-down as soon as a refresh falls due. A refresh that is owed takes priority over every host request. If more than one refresh is ever owed at the same time, a sticky error flag is set.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `cke` is 0 and the command pins carry NOP. In the first cycle after release, `cke` is 1 with NOP, and `ref_err` is 0. The command pins are {cs_n,ras_n,cas_n,we_n}, with NOP = 0111, precharge-all = 0010 and refresh = 0001.
- R2: While the banks stay closed and no request is made, auto-refresh commands (0001 with `cke` high) occur exactly `REF_INTERVAL` cycles apart.
- R3: When a refresh falls due while `bank_open` is 1, precharge-all (0010) is issued first. The refresh follows exactly `T_RP` cycles later, with NOP in the cycles between.
- R4: The `T_RC` cycles that follow any auto-refresh carry NOP with `cke` high.
- R5: With the banks closed and a refresh finished within `SR_WINDOW` cycles, `sleep_req` causes a self-refresh entry: code 0001 with `cke` low in the same cycle, `T_RC`+1 cycles after that refresh. After the entry, `cke` stays low with NOP for as long as no `wake_req` arrives, and no refresh is issued during that time.
- R6: If `sleep_req` arrives when the last refresh is `SR_WINDOW` or more cycles old, an auto-refresh with `cke` high is issued first. Self-refresh entry follows `T_RC`+1 cycles after that refresh.
- R7: A `wake_req` pulse during self-refresh raises `cke` in the next cycle with NOP. An auto-refresh follows `T_RC`+1 cycles after that rise.
- R8: If `sleep_req` is still high when self-refresh ends, the owed refresh (`cke` high) is issued before self-refresh is entered again. The new entry follows `T_RC`+1 cycles after that refresh.
- R9: In idle with the banks closed and nothing owed, `pd_req` lowers `cke` in the next cycle with NOP, and `cke` stays low after `pd_req` is dropped. A `wake_req` pulse raises `cke` in the next cycle with NOP.
- R10: `pd_req` has no effect while `bank_open` is 1, and `cke` stays high.
- R11: A refresh falling due ends power-down: `cke` rises and an auto-refresh follows. `ref_err` becomes 1 and stays 1 once more than one refresh is owed, and it stays 0 while refreshes keep pace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Host request to enter self-refresh (level) |
| wake_req | input | 1 | Host pulse to leave self-refresh or power-down |
| pd_req | input | 1 | Host request to enter power-down (level) |
| bank_open | input | 1 | High while any bank is active |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| ref_err | output | 1 | Sticky flag: more than one refresh owed |

## Verification
The assertions assume that `T_RP` is at least 2 and that `SR_WINDOW` is larger than `T_RC`+1. Under these conditions a precharge is always followed by a NOP, and a self-refresh entry always lands inside the window opened by the refresh just before it. They also assume that `wake_req` is a one-cycle pulse that is never raised together with `pd_req`. The stimulus keeps to these limits: it drops `pd_req` before it pulses `wake_req`, and it changes `bank_open` only when no precharge has been issued. It also times every request to fall between two refresh ticks, so that no owed refresh lands in the middle of a sequence that a check observes.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int REF_INTERVAL = 780,
  parameter int T_RP         = 3,
  parameter int T_RC         = 7,
  parameter int SR_WINDOW    = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic pd_req,
  input  logic bank_open,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke,
  output logic ref_err
);
  localparam int CW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam int SW = $clog2(SR_WINDOW + 1);
  localparam int WW = $clog2((T_RC > T_RP ? T_RC : T_RP) + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;

  typedef enum logic [3:0] {
    S_RST, S_IDLE, S_PRE, S_WRP, S_REF, S_WRC, S_SRE, S_SELF, S_SRX, S_PD
  } state_t;

  state_t         state;
  logic [CW-1:0]  cnt;
  logic [1:0]     owed, owed_nx;
  logic [SW-1:0]  since;
  logic [WW-1:0]  wcnt;
  logic [3:0]     cmd;

  wire frozen = (state == S_SRE) || (state == S_SELF);
  wire tick   = !frozen && (cnt == CW'(REF_INTERVAL - 1));
  wire issue  = (state == S_REF);
  wire recent = since < SW'(SR_WINDOW);
  wire due    = owed != 2'd0;

  always_comb begin
    cmd = C_NOP;
    cke = 1'b1;
    case (state)
      S_RST, S_SELF, S_PD: cke = 1'b0;
      S_PRE:               cmd = C_PRE;
      S_REF:               cmd = C_REF;
      S_SRE:               begin cmd = C_REF; cke = 1'b0; end
      default:             ;
    endcase
  end
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  always_comb begin
    owed_nx = owed;
    if (tick && !issue && owed != 2'd3) owed_nx = owed + 2'd1;
    else if (!tick && issue && due)     owed_nx = owed - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_RST;
      cnt     <= '0;
      owed    <= '0;
      since   <= SW'(SR_WINDOW);
      wcnt    <= '0;
      ref_err <= 1'b0;
    end else begin
      ref_err <= ref_err | owed[1];
      cnt     <= (frozen || tick) ? '0 : cnt + 1'b1;
      if (frozen)                 owed <= 2'd0;
      else if (state == S_SRX)    owed <= 2'd1;
      else                        owed <= owed_nx;
      if (issue || state == S_SELF) since <= '0;
      else if (recent)              since <= since + 1'b1;

      case (state)
        S_RST:  state <= S_IDLE;
        S_IDLE:
          if (due || (sleep_req && !recent)) state <= bank_open ? S_PRE : S_REF;
          else if (sleep_req)                state <= bank_open ? S_PRE : S_SRE;
          else if (pd_req && !bank_open)     state <= S_PD;
        S_PRE:  begin wcnt <= WW'(T_RP - 2); state <= S_WRP; end
        S_WRP:  if (wcnt == '0) state <= S_REF; else wcnt <= wcnt - 1'b1;
        S_REF:  begin wcnt <= WW'(T_RC - 2); state <= S_WRC; end
        S_WRC:  if (wcnt == '0) state <= S_IDLE; else wcnt <= wcnt - 1'b1;
        S_SRE:  state <= S_SELF;
        S_SELF: if (wake_req) state <= S_SRX;
        S_SRX:  begin wcnt <= WW'(T_RC - 2); state <= S_WRC; end
        S_PD:   if (wake_req || due) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  cke_wake_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> cmd == C_NOP);
  // R5
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> cmd == C_NOP);
  // R3
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_PRE |=> cmd == C_NOP);
  // R6
  sre_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && !cke) |-> recent);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err |=> ref_err);
endmodule

// File: tb/sim_sdram_refresh_sched.sv
module sim_sdram_refresh_sched;
  localparam int RI = 60, TRP = 3, TRC = 5, SRW = 40;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001;
  // {pd_req, wake_req, bank_open, expected cke}
  localparam logic [3:0] VEC [11] = '{
    4'b0001, 4'b1000, 4'b1000, 4'b0000, 4'b0101, 4'b0001,
    4'b1011, 4'b1011, 4'b1000, 4'b0101, 4'b0001};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, wake_req = 0, pd_req = 0, bank_open = 0;
  logic cs_n, ras_n, cas_n, we_n, cke, ref_err;
  logic cs1, ras1, cas1, we1, cke1, err1;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_refresh_sched #(.REF_INTERVAL(RI), .T_RP(TRP), .T_RC(TRC), .SR_WINDOW(SRW)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .pd_req(pd_req), .bank_open(bank_open), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .ref_err(ref_err));

  sdram_refresh_sched #(.REF_INTERVAL(4), .T_RP(TRP), .T_RC(TRC), .SR_WINDOW(4)) u1 (
    .clk(clk), .rst_n(rst_n), .sleep_req(1'b0), .wake_req(1'b0),
    .pd_req(1'b0), .bank_open(1'b1), .cs_n(cs1), .ras_n(ras1),
    .cas_n(cas1), .we_n(we1), .cke(cke1), .ref_err(err1));

  wire [3:0] c0 = {cs_n, ras_n, cas_n, we_n};

  task automatic step; @(negedge clk); cyc++; endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wait_for(input logic [3:0] code, input logic ck, input int maxc,
                          input string tag, output int t);
    t = -1;
    for (int i = 0; i < maxc; i++) begin
      step();
      if (c0 == code && cke == ck) begin t = cyc; break; end
    end
    if (t < 0) check(0, tag, -1, int'(code));
  endtask

  initial begin
    int a, b, p, r, s, t0, x, f, bad;
    repeat (3) step();
    check(cke == 0 && c0 == NOP, "R1 reset pins", {cke, c0}, {1'b0, NOP});
    check(err1 == 0, "R11 err clear in reset", err1, 0);
    rst_n = 1;
    step();
    check(cke == 1 && c0 == NOP, "R1 cke after release", {cke, c0}, {1'b1, NOP});

    wait_for(REF, 1, 200, "R2 first refresh", a);
    bad = 0;
    for (int i = 0; i < TRC; i++) begin step(); if (c0 != NOP || !cke) bad++; end
    check(bad == 0, "R4 nop after refresh", bad, 0);
    wait_for(REF, 1, 200, "R2 second refresh", b);
    check(b - a == RI, "R2 refresh spacing", b - a, RI);

    bank_open = 1;
    wait_for(PRE, 1, 200, "R3 precharge", p);
    bank_open = 0;
    wait_for(REF, 1, 20, "R3 refresh after precharge", r);
    check(r - p == TRP, "R3 precharge to refresh", r - p, TRP);

    sleep_req = 1;
    wait_for(REF, 0, 20, "R5 self-refresh entry", s);
    check(s - r == TRC + 1, "R5 entry delay", s - r, TRC + 1);
    sleep_req = 0;
    bad = 0;
    for (int i = 0; i < 100; i++) begin step(); if (cke || c0 != NOP) bad++; end
    check(bad == 0, "R5 held in self-refresh", bad, 0);

    wake_req = 1; step(); wake_req = 0; t0 = cyc;
    check(cke == 1 && c0 == NOP, "R7 exit pins", {cke, c0}, {1'b1, NOP});
    wait_for(REF, 1, 20, "R7 refresh after exit", x);
    check(x - t0 == TRC + 1, "R7 exit to refresh", x - t0, TRC + 1);

    repeat (42) step();
    sleep_req = 1;
    wait_for(REF, 1, 3, "R6 forced refresh", f);
    wait_for(REF, 0, 20, "R6 entry after refresh", s);
    check(s - f == TRC + 1, "R6 refresh to entry", s - f, TRC + 1);

    repeat (10) step();
    wake_req = 1; step(); wake_req = 0; t0 = cyc;
    wait_for(REF, 1, 20, "R8 refresh before re-entry", x);
    check(x - t0 == TRC + 1, "R8 exit to refresh", x - t0, TRC + 1);
    wait_for(REF, 0, 20, "R8 re-entry", s);
    check(s - x == TRC + 1, "R8 refresh to re-entry", s - x, TRC + 1);
    sleep_req = 0;
    repeat (5) step();
    wake_req = 1; step(); wake_req = 0;
    wait_for(REF, 1, 20, "R7 refresh after second exit", x);
    repeat (TRC) step();

    foreach (VEC[i]) begin
      {pd_req, wake_req, bank_open} = VEC[i][3:1];
      step();
      check(cke == VEC[i][0] && c0 == NOP, VEC[i][1] ? "R10 vector" : "R9 vector",
            {cke, c0}, {VEC[i][0], NOP});
    end
    {pd_req, wake_req, bank_open} = 3'b000;

    pd_req = 1;
    repeat (2) step();
    check(cke == 0, "R9 power-down before tick", cke, 0);
    wait_for(REF, 1, 100, "R11 refresh ends power-down", x);
    check(x > 0, "R11 refresh ends power-down", x, 1);
    pd_req = 0;
    repeat (4) step();
    check(ref_err == 0, "R11 no error when on pace", ref_err, 0);
    check(err1 == 1, "R11 error on backlog", err1, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule